// File: doc/BRIEF.md
# Horizontal Sync Activity Detector

This block watches a horizontal sync line and reports through one status output whether a live video stream is present. The sync input is brought into the pixel-clock domain through a synchronizer chain, and every transition on it, rising or falling, counts as a sign of activity. Because edges are counted rather than levels, the detector works for either sync polarity.

Time is measured in pulses of a free-running reference tick, so the timing does not depend on the pixel rate. When no sync edge arrives for a set number of ticks, the status output is dropped. That timeout is slow enough for loss to be signalled within 50 ms of sync stopping. Raising the output again is faster but stricter. It needs a run of consecutive edges, none separated from the one before by a full timeout, which keeps recovery inside 2 ms. The status output is meant to gate panel driver and backlight power, so it stays low out of reset until a stream has qualified.

Top module: `sync_activity_det`

## Requirements
- R1: After reset the status output `sync_ok` is 0, and it stays 0 for as long as no sync edge arrives, however many ticks pass.
- R2: A level change applied to `hsync_in` before a rising clock edge takes effect at the status output on the third rising clock edge, counting that first edge, because there are two synchronizer flops and one state register.
- R3: Rising and falling transitions of `hsync_in` both count as activity, so a toggling line qualifies whatever its idle level is.
- R4: While `sync_ok` is 0, it is set by the QUAL_EDGES-th edge of an unbroken run (default 16) and not by any earlier edge of that run.
- R5: If LOSS_TICKS ticks pass with no edge during qualification, the run is discarded, and the next edge counts as the first of a new run.
- R6: While `sync_ok` is 1, it falls one clock after the tick that completes LOSS_TICKS ticks with no edge.
- R7: When an edge and a tick reach the timer in the same cycle, the edge wins. The gap restarts at zero and the tick is not counted.
- R8: `sync_ok` stays 1 as long as every gap between edges is shorter than LOSS_TICKS ticks.
- R9: After a loss, `sync_ok` rises again only after a complete new run of QUAL_EDGES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous to clk, either polarity |
| ref_tick | input | 1 | One-cycle pulse from a free-running reference timebase |
| sync_ok | output | 1 | 1 while sync activity is present and qualified |

## Verification
Two events can coincide: a synchronized sync edge arriving at the gap timer, and a reference tick that would advance that timer or complete its timeout. The bench provokes this on purpose. It drives the tick two cycles after a sync toggle, which is the cycle in which the edge reaches the timer. It then checks that exactly LOSS_TICKS further ticks are needed to drop the output. During random stimulus, edges that land in the same cycle as the timeout expiring are judged by a bench model. That model lets expiry win: it clears the output and restarts the run at one.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // Tick count since the last edge. An edge restarts it, and it stops at the limit.
  function automatic int unsigned gap_step(int unsigned gap, bit edge_seen, bit tick,
                                           int unsigned limit);
    if (edge_seen)                 return 0;
    if (tick && gap < limit)       return gap + 1;
    return gap;
  endfunction

  // Length of the current edge run. An expired gap breaks it.
  function automatic int unsigned run_step(int unsigned run, bit edge_seen, bit expired,
                                           int unsigned target);
    if (edge_seen) begin
      if (expired)                 return 1;
      if (run < target)            return run + 1;
      return target;
    end
    if (expired)                   return 0;
    return run;
  endfunction

endpackage

// File: rtl/sad_sync_edge.sv
module sad_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  assign edge_pulse = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/sad_gap_timer.sv
module sad_gap_timer #(
  parameter int LOSS_TICKS = 40,
  localparam int GAP_W = $clog2(LOSS_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_pulse,
  input  logic             tick,
  output logic [GAP_W-1:0] gap_cnt,
  output logic             expired
);
  localparam logic [GAP_W-1:0] LIMIT = GAP_W'(LOSS_TICKS);

  // Reset to the expired value so that the first edge opens a fresh run.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gap_cnt <= LIMIT;
    else        gap_cnt <= GAP_W'(sad_pkg::gap_step(32'(gap_cnt), edge_pulse, tick,
                                                    LOSS_TICKS));

  assign expired = (gap_cnt == LIMIT);
endmodule

// File: rtl/sad_qualifier.sv
module sad_qualifier #(
  parameter int QUAL_EDGES = 16,
  localparam int RUN_W = $clog2(QUAL_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_pulse,
  input  logic             expired,
  output logic [RUN_W-1:0] run_cnt,
  output logic             qual_hit,
  output logic             status
);
  logic [RUN_W-1:0] run_nxt;

  always_comb begin
    run_nxt  = RUN_W'(sad_pkg::run_step(32'(run_cnt), edge_pulse, expired, QUAL_EDGES));
    qual_hit = edge_pulse && !expired && (32'(run_nxt) >= QUAL_EDGES);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_cnt <= '0;
      status  <= 1'b0;
    end else begin
      run_cnt <= run_nxt;
      if (expired)       status <= 1'b0;
      else if (qual_hit) status <= 1'b1;
    end
endmodule

// File: rtl/sync_activity_det.sv
module sync_activity_det #(
  parameter int LOSS_TICKS  = 40,
  parameter int QUAL_EDGES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  input  logic ref_tick,
  output logic sync_ok
);
  localparam int GAP_W = $clog2(LOSS_TICKS + 1);
  localparam int RUN_W = $clog2(QUAL_EDGES + 1);

  logic             edge_w;
  logic             timeout_w;
  logic             qual_hit_w;
  logic [GAP_W-1:0] gap_w;
  logic [RUN_W-1:0] run_w;

  sad_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_in(hsync_in), .edge_pulse(edge_w)
  );

  sad_gap_timer #(.LOSS_TICKS(LOSS_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .edge_pulse(edge_w), .tick(ref_tick),
    .gap_cnt(gap_w), .expired(timeout_w)
  );

  sad_qualifier #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
    .clk(clk), .rst_n(rst_n), .edge_pulse(edge_w), .expired(timeout_w),
    .run_cnt(run_w), .qual_hit(qual_hit_w), .status(sync_ok)
  );
endmodule

// File: rtl/sync_activity_det_chk.sv
module sync_activity_det_chk #(
  parameter int LOSS_TICKS = 40,
  parameter int QUAL_EDGES = 16,
  localparam int GAP_W = $clog2(LOSS_TICKS + 1),
  localparam int RUN_W = $clog2(QUAL_EDGES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_ok,
  input logic             edge_w,
  input logic             timeout_w,
  input logic [GAP_W-1:0] gap_w,
  input logic [RUN_W-1:0] run_w
);
  // R1
  rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(edge_w));

  // R4
  rise_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> (32'(run_w) == QUAL_EDGES));

  // R6
  loss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_w |=> !sync_ok);

  // R7
  edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> (gap_w == '0));

  // R8
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && !timeout_w) |=> sync_ok);

  // R5
  run_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_w && !edge_w) |=> (run_w == '0));
endmodule

bind sync_activity_det sync_activity_det_chk #(
  .LOSS_TICKS(LOSS_TICKS), .QUAL_EDGES(QUAL_EDGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .edge_w(edge_w),
  .timeout_w(timeout_w), .gap_w(gap_w), .run_w(run_w)
);

// File: tb/sync_activity_det_tb_top.sv
module sync_activity_det_tb_top;
  localparam int LOSS = 6;
  localparam int QUAL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0;
  logic tick = 1'b0;
  logic sync_ok;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   cmp_en = 1'b0;

  always #10 clk = ~clk;

  sync_activity_det #(.LOSS_TICKS(LOSS), .QUAL_EDGES(QUAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync), .ref_tick(tick), .sync_ok(sync_ok)
  );

  // Event model: the line is seen two clocks late, and the state register adds one more.
  logic        h1, h2, h3;
  int unsigned m_since;
  int unsigned m_run;
  bit          m_ok;

  function automatic bit gap_over(int unsigned since);
    return since >= LOSS;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; m_since = LOSS; m_run = 0; m_ok = 0;
    end else begin
      bit seen, over;
      over = gap_over(m_since);
      seen = (h2 != h3);
      h3 = h2; h2 = h1; h1 = hsync;
      if (over) m_ok = 0;
      if (seen) begin
        if (over) m_run = 1;
        else if (m_run < QUAL) m_run++;
        m_since = 0;
        if (!over && m_run >= QUAL) m_ok = 1;
      end else if (over) m_run = 0;
      else if (tick) m_since++;
    end
  end

  task automatic check(bit got, bit exp, string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: sync_ok=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n && cmp_en) check(sync_ok, m_ok, "R4 R5 R6 R8 model");

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic toggle_spaced();
    @(negedge clk) hsync = ~hsync;
    idle(2);
    pulse_tick();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin pulse_tick(); idle(1); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5AD1));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(sync_ok, 1'b0, "R1 reset");
    cmp_en = 1'b1;
    ticks(20);
    check(sync_ok, 1'b0, "R1 idle ticks");

    // R3 R4: edges of both directions, the 15th is not enough
    for (int i = 0; i < QUAL - 1; i++) toggle_spaced();
    idle(4);
    check(sync_ok, 1'b0, "R4 one edge short");
    @(negedge clk) hsync = ~hsync;
    @(negedge clk); @(negedge clk);
    check(sync_ok, 1'b0, "R2 second edge");
    @(negedge clk);
    check(sync_ok, 1'b1, "R2 R3 R4 third edge");

    // R8
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) hsync = ~hsync;
      ticks(LOSS - 1);
    end
    check(sync_ok, 1'b1, "R8 long gaps held");

    // R6: ticks continue from the last edge of the loop
    ticks(1);
    check(sync_ok, 1'b1, "R6 before limit");
    pulse_tick();
    check(sync_ok, 1'b1, "R6 limit tick registered");
    @(negedge clk);
    check(sync_ok, 1'b0, "R6 dropped");

    // R9 and R5
    for (int i = 0; i < QUAL - 1; i++) toggle_spaced();
    idle(4);
    check(sync_ok, 1'b0, "R9 partial run after loss");
    ticks(LOSS);
    toggle_spaced();
    idle(4);
    check(sync_ok, 1'b0, "R5 broken run restarted");
    for (int i = 0; i < QUAL - 2; i++) toggle_spaced();
    idle(4);
    check(sync_ok, 1'b0, "R5 new run one short");
    toggle_spaced();
    idle(2);
    check(sync_ok, 1'b1, "R5 R9 new run complete");

    // R7: the tick lands in the cycle where the edge reaches the timer
    @(negedge clk) hsync = ~hsync;
    @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    ticks(LOSS - 1);
    check(sync_ok, 1'b1, "R7 coincident tick not counted");
    pulse_tick();
    @(negedge clk);
    check(sync_ok, 1'b0, "R7 drop after full gap");

    // random traffic with quiet stretches
    for (int seg = 0; seg < 60; seg++) begin
      int unsigned tprob = ($urandom % 3 == 0) ? 0 : 4 + $urandom % 20;
      for (int c = 0; c < 150; c++) begin
        @(negedge clk);
        hsync = (tprob != 0 && $urandom % tprob == 0) ? ~hsync : hsync;
        tick  = ($urandom % 5 == 0);
      end
    end
    @(negedge clk) tick = 1'b0;
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule